// File: doc/BRIEF.md
# Alternating-Buffer Video Packetizer

This block takes a parallel pixel stream and turns it into numbered packets for a downstream transport. Each pixel arrives with an enable strobe (`pix_valid`, one pixel per asserted clock), plus a line-start level `hsync` and a frame-start level `vsync`. Pixels are written into a pool of equal-sized buffers. Two producer threads own the buffers in turn: even buffers belong to thread 0 and odd buffers to thread 1. When one buffer fills, the next pixel goes straight into the next buffer with no lost cycle.

Every packet begins with a reserved header region of 128 bits that pixel data never occupies. The header is completed with stream numbering, and only then is the buffer released. A single consumer port drains the buffers in strict rotation through a valid/ready handshake, and marks the final word of each packet. If the producer reaches a buffer the consumer has not yet drained, the block raises a sticky overflow flag and drops pixels until that buffer is freed.

Top module: `pixel_buffer_packer`

## Requirements
- R1: A synchronous reset empties every buffer, selects thread 0 and clears all counters. After reset `out_valid`, `out_last`, `overflow` and `thread_sel` are 0, and the first packet after reset carries sequence 0, frame 0, line 0 and offset 0.
- R2: With the default parameters a packet has 16 words of 16 bits. Words 8 to 15 hold the buffer's pixels, zero-extended and in arrival order.
- R3: When the pixel that fills a buffer is accepted, the next pixel is written to the first payload word of the following buffer on the very next clock. From the clock edge that completes a buffer, `thread_sel` equals bit 0 of the index of the buffer now being filled.
- R4: Words 0 to 7 form a 128-bit header, sent low word first. Bits [31:0] hold the sequence count, [47:32] the frame count, [63:48] the line index, [79:64] the pixel offset, and [127:80] are zero.
- R5: The frame count increments on a rising edge of `vsync`, which also clears the line index and the pixel offset. The line index increments on a rising edge of `hsync`, which also clears the pixel offset. The offset counts the `pix_valid` cycles since then. A header holds these values as they stood at the buffer's first pixel.
- R6: Buffers are released in the order 0, 1, …, NUM_BUF-1, then wrap to 0. A buffer becomes visible at the port only after its header has been written. Each packet starts at word 0.
- R7: A word transfers when `out_valid` and `out_ready` are both high. While `out_ready` is low, `out_valid` and `out_data` stay unchanged. `out_last` is high on the final word of each packet.
- R8: If a pixel arrives while the buffer due to be filled still waits to be drained, the pixel is dropped and `overflow` is set. `overflow` stays set until reset. Writing resumes at that buffer's first payload word once it is drained.
- R9: The sequence count starts at 0 and increments by one for each completed buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_valid | input | 1 | Pixel strobe |
| pix_data | input | PIX_W | Pixel value |
| hsync | input | 1 | Line-start level |
| vsync | input | 1 | Frame-start level |
| out_valid | output | 1 | Consumer word valid |
| out_ready | input | 1 | Consumer accepts word |
| out_data | output | OUT_W | Packet word |
| out_last | output | 1 | Final word of a packet |
| overflow | output | 1 | Sticky drop indicator |
| thread_sel | output | 1 | Producer thread now filling |

## Verification
The hardest situation to reach from the ports is overflow with recovery. The producer has to wrap all the way around the pool and land on a buffer that is still full. The consumer then has to free exactly that buffer, and the producer has to resume at its first payload word, with header offsets that still count the dropped pixels. The stimulus holds `out_ready` low while more than a pool's worth of back-to-back pixels arrive, so the producer wraps onto an undrained buffer. It then releases the port and sends fresh pixels. The stimulus also places a buffer boundary inside a back-to-back burst, to expose any lost cycle at the thread switch.

// File: rtl/vpk_pkg.sv
package vpk_pkg;
   localparam int HDR_BITS = 128;
   localparam int CNT_W    = 16;

   typedef struct packed {
      logic [47:0]      pad;
      logic [CNT_W-1:0] pix_off;
      logic [CNT_W-1:0] line;
      logic [CNT_W-1:0] frame;
      logic [31:0]      seq;
   } vpk_hdr_t;
endpackage

// File: rtl/vpk_sync_track.sv
module vpk_sync_track
   import vpk_pkg::*;
(
   input  logic             clk,
   input  logic             rst,
   input  logic             pix_valid,
   input  logic             hsync,
   input  logic             vsync,
   output logic [CNT_W-1:0] frame_cnt,
   output logic [CNT_W-1:0] line_idx,
   output logic [CNT_W-1:0] pix_off
);
   logic hs_q, vs_q;
   logic hs_rise, vs_rise;

   assign hs_rise = hsync && !hs_q;
   assign vs_rise = vsync && !vs_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         hs_q      <= 1'b0;
         vs_q      <= 1'b0;
         frame_cnt <= '0;
         line_idx  <= '0;
         pix_off   <= '0;
      end else begin
         hs_q <= hsync;
         vs_q <= vsync;
         if (vs_rise) begin
            frame_cnt <= frame_cnt + 1'b1;
            line_idx  <= '0;
            pix_off   <= '0;
         end else if (hs_rise) begin
            line_idx <= line_idx + 1'b1;
            pix_off  <= '0;
         end else if (pix_valid) begin
            pix_off <= pix_off + 1'b1;
         end
      end
   end

   AST_FRAME_STEP: assert property (@(posedge clk) disable iff (rst)
      (vsync && !vs_q) |=> (line_idx == '0 && frame_cnt == $past(frame_cnt) + 1'b1)); // R5
endmodule

// File: rtl/vpk_fill_ctrl.sv
module vpk_fill_ctrl
   import vpk_pkg::*;
#(
   parameter  int NUM_BUF   = 8,
   parameter  int PAY_WORDS = 8,
   localparam int BI_W      = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1,
   localparam int PTR_W     = (PAY_WORDS > 1) ? $clog2(PAY_WORDS) : 1
)(
   input  logic               clk,
   input  logic               rst,
   input  logic               pix_valid,
   input  logic [CNT_W-1:0]   frame_cnt,
   input  logic [CNT_W-1:0]   line_idx,
   input  logic [CNT_W-1:0]   pix_off,
   input  logic               clr_en,
   input  logic [BI_W-1:0]    clr_idx,
   output logic               wr_en,
   output logic [BI_W-1:0]    wr_buf,
   output logic [PTR_W-1:0]   wr_ptr,
   output logic               hdr_we,
   output logic [BI_W-1:0]    hdr_idx,
   output vpk_hdr_t           hdr_val,
   output logic [NUM_BUF-1:0] full_vec,
   output logic               overflow,
   output logic               thread_sel
);
   logic             accept, last_slot, first_slot;
   logic [BI_W-1:0]  nxt_buf;
   logic [31:0]      seq_q;
   logic [CNT_W-1:0] cap_frame, cap_line, cap_off;
   logic             pend_q;
   logic [BI_W-1:0]  pend_idx;

   assign accept     = pix_valid && !full_vec[wr_buf];
   assign last_slot  = (wr_ptr == PTR_W'(PAY_WORDS - 1));
   assign first_slot = (wr_ptr == '0);
   assign nxt_buf    = (wr_buf == BI_W'(NUM_BUF - 1)) ? '0 : wr_buf + 1'b1;
   assign wr_en      = accept;
   assign hdr_we     = accept && last_slot;
   assign hdr_idx    = wr_buf;

   always_comb begin
      hdr_val         = '0;
      hdr_val.seq     = seq_q;
      hdr_val.frame   = first_slot ? frame_cnt : cap_frame;
      hdr_val.line    = first_slot ? line_idx  : cap_line;
      hdr_val.pix_off = first_slot ? pix_off   : cap_off;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_buf     <= '0;
         wr_ptr     <= '0;
         seq_q      <= '0;
         cap_frame  <= '0;
         cap_line   <= '0;
         cap_off    <= '0;
         pend_q     <= 1'b0;
         pend_idx   <= '0;
         full_vec   <= '0;
         overflow   <= 1'b0;
         thread_sel <= 1'b0;
      end else begin
         if (accept) begin
            if (first_slot) begin
               cap_frame <= frame_cnt;
               cap_line  <= line_idx;
               cap_off   <= pix_off;
            end
            if (last_slot) begin
               wr_ptr     <= '0;
               wr_buf     <= nxt_buf;
               seq_q      <= seq_q + 32'd1;
               thread_sel <= nxt_buf[0];
            end else begin
               wr_ptr <= wr_ptr + 1'b1;
            end
         end
         if (pix_valid && full_vec[wr_buf])
            overflow <= 1'b1;
         pend_q   <= hdr_we;
         pend_idx <= wr_buf;
         for (int b = 0; b < NUM_BUF; b++) begin
            if (pend_q && pend_idx == BI_W'(b))
               full_vec[b] <= 1'b1;
            else if (clr_en && clr_idx == BI_W'(b))
               full_vec[b] <= 1'b0;
         end
      end
   end

   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
      overflow |=> overflow); // R8
   AST_THREAD_FLIP: assert property (@(posedge clk) disable iff (rst)
      (accept && last_slot) |=> (thread_sel != $past(thread_sel))); // R3
   AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
      hdr_we |=> (seq_q == $past(seq_q) + 32'd1)); // R9
endmodule

// File: rtl/vpk_drain.sv
module vpk_drain
   import vpk_pkg::*;
#(
   parameter  int NUM_BUF   = 8,
   parameter  int BUF_WORDS = 16,
   parameter  int HDR_WORDS = 8,
   parameter  int OUT_W     = 16,
   localparam int BI_W      = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1,
   localparam int RP_W      = (BUF_WORDS > 1) ? $clog2(BUF_WORDS) : 1
)(
   input  logic               clk,
   input  logic               rst,
   input  logic [NUM_BUF-1:0] full_vec,
   input  logic               out_ready,
   input  vpk_hdr_t           hdr_cur,
   input  logic [OUT_W-1:0]   pay_word,
   output logic [BI_W-1:0]    rd_buf,
   output logic [RP_W-1:0]    rd_ptr,
   output logic               out_valid,
   output logic [OUT_W-1:0]   out_data,
   output logic               out_last,
   output logic               clr_en,
   output logic [BI_W-1:0]    clr_idx
);
   logic [OUT_W-1:0] hdr_word [HDR_WORDS];
   logic             at_end, xfer;

   for (genvar g = 0; g < HDR_WORDS; g++) begin : g_hdr_slice
      assign hdr_word[g] = hdr_cur[g*OUT_W +: OUT_W];
   end

   assign out_valid = full_vec[rd_buf];
   assign at_end    = (rd_ptr == RP_W'(BUF_WORDS - 1));
   assign out_last  = out_valid && at_end;
   assign xfer      = out_valid && out_ready;
   assign clr_en    = xfer && at_end;
   assign clr_idx   = rd_buf;

   always_comb begin
      out_data = pay_word;
      for (int i = 0; i < HDR_WORDS; i++)
         if (rd_ptr == RP_W'(i))
            out_data = hdr_word[i];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rd_buf <= '0;
         rd_ptr <= '0;
      end else if (xfer) begin
         if (at_end) begin
            rd_ptr <= '0;
            rd_buf <= (rd_buf == BI_W'(NUM_BUF - 1)) ? '0 : rd_buf + 1'b1;
         end else begin
            rd_ptr <= rd_ptr + 1'b1;
         end
      end
   end

   AST_HOLD_WORD: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R7
   AST_START_AT_HDR: assert property (@(posedge clk) disable iff (rst)
      $rose(out_valid) |-> (rd_ptr == '0)); // R6
endmodule

// File: rtl/pixel_buffer_packer.sv
module pixel_buffer_packer
   import vpk_pkg::*;
#(
   parameter int PIX_W     = 12,
   parameter int OUT_W     = 16,
   parameter int NUM_BUF   = 8,
   parameter int BUF_WORDS = 16
)(
   input  logic             clk,
   input  logic             rst,
   input  logic             pix_valid,
   input  logic [PIX_W-1:0] pix_data,
   input  logic             hsync,
   input  logic             vsync,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [OUT_W-1:0] out_data,
   output logic             out_last,
   output logic             overflow,
   output logic             thread_sel
);
   localparam int HDR_WORDS = HDR_BITS / OUT_W;
   localparam int PAY_WORDS = BUF_WORDS - HDR_WORDS;
   localparam int TOTAL     = NUM_BUF * PAY_WORDS;
   localparam int ADDR_W    = (TOTAL > 1) ? $clog2(TOTAL) : 1;
   localparam int BI_W      = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1;
   localparam int PTR_W     = (PAY_WORDS > 1) ? $clog2(PAY_WORDS) : 1;
   localparam int RP_W      = (BUF_WORDS > 1) ? $clog2(BUF_WORDS) : 1;

   if (OUT_W < PIX_W || (HDR_BITS % OUT_W) != 0) begin : g_bad_width
      $error("word width must hold a pixel and divide the header");
   end
   if (NUM_BUF < 2 || (NUM_BUF % 2) != 0) begin : g_bad_pool
      $error("pool must hold an even number of buffers, at least two");
   end
   if (PAY_WORDS < 1) begin : g_bad_size
      $error("buffer must exceed its header");
   end

   logic [CNT_W-1:0]   frame_cnt, line_idx, pix_off;
   logic               wr_en, hdr_we, clr_en;
   logic [BI_W-1:0]    wr_buf, hdr_idx, rd_buf, clr_idx;
   logic [PTR_W-1:0]   wr_ptr;
   logic [RP_W-1:0]    rd_ptr;
   logic [NUM_BUF-1:0] full_vec;
   vpk_hdr_t           hdr_val, hdr_cur;
   vpk_hdr_t           hdr_q [NUM_BUF];
   logic [OUT_W-1:0]   mem_q [TOTAL];
   logic [OUT_W-1:0]   pix_word, pay_word;
   logic [ADDR_W-1:0]  wr_addr, rd_addr;

   if (OUT_W > PIX_W) begin : g_pad
      assign pix_word = {{(OUT_W-PIX_W){1'b0}}, pix_data};
   end else begin : g_nopad
      assign pix_word = pix_data;
   end

   vpk_sync_track u_sync (
      .clk(clk), .rst(rst), .pix_valid(pix_valid), .hsync(hsync), .vsync(vsync),
      .frame_cnt(frame_cnt), .line_idx(line_idx), .pix_off(pix_off)
   );

   vpk_fill_ctrl #(.NUM_BUF(NUM_BUF), .PAY_WORDS(PAY_WORDS)) u_fill (
      .clk(clk), .rst(rst), .pix_valid(pix_valid),
      .frame_cnt(frame_cnt), .line_idx(line_idx), .pix_off(pix_off),
      .clr_en(clr_en), .clr_idx(clr_idx),
      .wr_en(wr_en), .wr_buf(wr_buf), .wr_ptr(wr_ptr),
      .hdr_we(hdr_we), .hdr_idx(hdr_idx), .hdr_val(hdr_val),
      .full_vec(full_vec), .overflow(overflow), .thread_sel(thread_sel)
   );

   always_comb begin
      wr_addr = ADDR_W'(int'(wr_buf) * PAY_WORDS + int'(wr_ptr));
      if (int'(rd_ptr) >= HDR_WORDS)
         rd_addr = ADDR_W'(int'(rd_buf) * PAY_WORDS + int'(rd_ptr) - HDR_WORDS);
      else
         rd_addr = ADDR_W'(int'(rd_buf) * PAY_WORDS);
   end

   always_ff @(posedge clk) begin
      if (wr_en)
         mem_q[wr_addr] <= pix_word;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int b = 0; b < NUM_BUF; b++)
            hdr_q[b] <= '0;
      end else if (hdr_we) begin
         hdr_q[hdr_idx] <= hdr_val;
      end
   end

   assign pay_word = mem_q[rd_addr];
   assign hdr_cur  = hdr_q[rd_buf];

   vpk_drain #(.NUM_BUF(NUM_BUF), .BUF_WORDS(BUF_WORDS), .HDR_WORDS(HDR_WORDS),
               .OUT_W(OUT_W)) u_drain (
      .clk(clk), .rst(rst), .full_vec(full_vec), .out_ready(out_ready),
      .hdr_cur(hdr_cur), .pay_word(pay_word),
      .rd_buf(rd_buf), .rd_ptr(rd_ptr),
      .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
      .clr_en(clr_en), .clr_idx(clr_idx)
   );

   AST_NO_LIVE_WRITE: assert property (@(posedge clk) disable iff (rst)
      (wr_en && out_valid) |-> (wr_buf != rd_buf)); // R8
   AST_RESET_QUIET: assert property (@(posedge clk)
      $past(rst) |-> (!out_valid && !overflow && !thread_sel)); // R1
endmodule

// File: tb/tb_pixel_buffer_packer.sv
module tb_pixel_buffer_packer;
   localparam int CLK_PERIOD = 10;
   localparam int PIX_W = 12;
   localparam int OUT_W = 16;
   localparam int NB    = 8;
   localparam int BW    = 16;
   localparam int HW    = 8;
   localparam int PW    = BW - HW;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic pix_valid = 1'b0;
   logic [PIX_W-1:0] pix_data = '0;
   logic hsync = 1'b0, vsync = 1'b0, out_ready = 1'b0;
   logic out_valid, out_last, overflow, thread_sel;
   logic [OUT_W-1:0] out_data;

   pixel_buffer_packer #(.PIX_W(PIX_W), .OUT_W(OUT_W), .NUM_BUF(NB), .BUF_WORDS(BW)) dut (
      .clk(clk), .rst(rst), .pix_valid(pix_valid), .pix_data(pix_data),
      .hsync(hsync), .vsync(vsync), .out_valid(out_valid), .out_ready(out_ready),
      .out_data(out_data), .out_last(out_last), .overflow(overflow),
      .thread_sel(thread_sel)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_cmp = 0, n_bad = 0;
   bit finished = 0;
   logic [16:0] exp_q[$];
   string tag_q[$];
   int m_buf, m_ptr, m_off, m_frame, m_line, mon_buf;
   int cf, cl, co;
   logic [31:0] m_seq;
   logic [15:0] pay [PW];
   bit m_busy [NB];
   bit m_ovf;

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic model_reset();
      m_buf = 0; m_ptr = 0; m_off = 0; m_frame = 0; m_line = 0; mon_buf = 0;
      m_seq = 0; m_ovf = 0; cf = 0; cl = 0; co = 0;
      for (int i = 0; i < NB; i++) m_busy[i] = 0;
      exp_q.delete(); tag_q.delete();
   endtask

   task automatic do_reset();
      rst = 1'b1;
      repeat (3) step();
      rst = 1'b0;
      model_reset();
   endtask

   task automatic idle(input int n);
      repeat (n) step();
   endtask

   task automatic frame_pulse();
      vsync = 1'b1; step(); vsync = 1'b0; step();
      m_frame++; m_line = 0; m_off = 0;
   endtask

   task automatic line_pulse();
      hsync = 1'b1; step(); hsync = 1'b0; step();
      m_line++; m_off = 0;
   endtask

   // driver: model the block from the requirements and queue expected words
   task automatic pixel(input logic [PIX_W-1:0] d);
      logic [127:0] hv;
      pix_valid = 1'b1;
      pix_data  = d;
      if (m_busy[m_buf]) begin
         m_ovf = 1;
      end else begin
         if (m_ptr == 0) begin cf = m_frame; cl = m_line; co = m_off; end
         pay[m_ptr] = {4'h0, d};
         m_ptr++;
         if (m_ptr == PW) begin
            hv = {48'h0, co[15:0], cl[15:0], cf[15:0], m_seq};
            for (int i = 0; i < HW; i++) begin
               exp_q.push_back({1'b0, hv[i*16 +: 16]});
               tag_q.push_back(i < 2 ? "R9 header sequence" : (i < 5 ? "R5 header numbering" : "R4 header padding"));
            end
            for (int i = 0; i < PW; i++) begin
               exp_q.push_back({(i == PW-1), pay[i]});
               tag_q.push_back(i == PW-1 ? "R7 last payload word" : "R2 payload word");
            end
            m_busy[m_buf] = 1;
            m_seq++;
            m_buf = (m_buf + 1) % NB;
            m_ptr = 0;
         end
      end
      m_off++;
      step();
      pix_valid = 1'b0;
      check(thread_sel == m_buf[0], "R3 thread select", thread_sel, m_buf[0]);
   endtask

   // monitor: pop and compare every transferred word
   always @(negedge clk) begin
      logic [16:0] e;
      string t;
      if (!rst && out_valid && out_ready) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R6 unexpected word", {15'h0, out_last, out_data}, 0);
         end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(out_data == e[15:0] && out_last == e[16], t, {15'h0, out_last, out_data}, {15'h0, e});
            if (e[16]) begin
               m_busy[mon_buf] = 0;
               mon_buf = (mon_buf + 1) % NB;
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL R6 watchdog: actual 0 expected 1");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [15:0] held;
      model_reset();
      do_reset();
      check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
      check(out_last == 1'b0, "R1 out_last after reset", out_last, 0);
      check(overflow == 1'b0, "R1 overflow after reset", overflow, 0);
      check(thread_sel == 1'b0, "R1 thread after reset", thread_sel, 0);

      out_ready = 1'b1;
      frame_pulse();
      line_pulse();
      // back-to-back burst crossing a buffer boundary (R3)
      for (int i = 0; i < 12; i++) pixel(12'h100 + 12'(i));
      line_pulse();
      for (int i = 0; i < 20; i++) begin pixel(12'hA00 + 12'(i * 7)); idle(1); end
      frame_pulse();
      line_pulse();
      line_pulse();
      for (int i = 0; i < 40; i++) begin pixel(12'(i * 37 + 5)); idle(1); end
      idle(60);
      check(overflow == 1'b0, "R8 no overflow when drained in time", overflow, 0);
      check(exp_q.size() == 0, "R6 all packets released", exp_q.size(), 0);

      // overflow: stall the consumer and wrap the pool (R8, R7)
      out_ready = 1'b0;
      for (int i = 0; i < 72; i++) pixel(12'hF00 - 12'(i));
      check(overflow == 1'b1, "R8 overflow raised", overflow, 1);
      check(m_ovf == 1'b1, "R8 model saw a drop", m_ovf, 1);
      check(out_valid == 1'b1, "R7 valid while stalled", out_valid, 1);
      check(out_data == exp_q[0][15:0], "R7 first word while stalled", out_data, exp_q[0][15:0]);
      held = out_data;
      idle(3);
      check(out_valid == 1'b1 && out_data == held, "R7 word held without ready", out_data, held);
      out_ready = 1'b1;
      idle(200);
      check(overflow == 1'b1, "R8 overflow sticky", overflow, 1);
      for (int i = 0; i < 16; i++) begin pixel(12'h0C0 + 12'(i)); idle(1); end
      idle(60);
      check(exp_q.size() == 0, "R8 resumed packets drained", exp_q.size(), 0);

      // reset in the middle of a buffer (R1)
      pixel(12'h111); pixel(12'h222); pixel(12'h333);
      do_reset();
      check(out_valid == 1'b0, "R1 out_valid after mid-stream reset", out_valid, 0);
      check(overflow == 1'b0, "R1 overflow cleared", overflow, 0);
      check(thread_sel == 1'b0, "R1 thread cleared", thread_sel, 0);
      for (int i = 0; i < PW; i++) begin pixel(12'h050 + 12'(i)); idle(1); end
      idle(40);
      check(exp_q.size() == 0, "R1 fresh packet after reset", exp_q.size(), 0);

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule